// File: doc/BRIEF.md
# Clock-Generator Interrupt Flag Unit

This block collects the three interrupt causes of a clock and reset generator and turns them into one interrupt request. The causes are a periodic timeout from a small programmable real-time counter, any change in the phase-locked-loop lock status, and any change in the self-clock (limp-home) state. Each cause owns a sticky flag and a local enable bit. Software clears a flag by writing a 1 to its bit. The flags that are set and enabled are ORed together, and the result is registered onto a single request line.

The lock status arrives asynchronously, as do the two self-clock causes: a failed clock quality check and loss of the external clock. Each passes through a two-flop synchronizer before it is used. The self-clock state follows its causes only while the self-clock enable bit is set. The real-time counter divides the block clock by a power of two that software selects. In pseudo-stop mode the counter counts only when a dedicated run bit allows it.

Top module: `cgen_irq_unit`

## Requirements
- R1: After reset the control register (address 0), the flag register (address 1), the period-select register (address 2) and `irq_o` all read 0.
- R2: The timeout flag (flag register bit 0) is set 2^(select+BASE_SHIFT) clock cycles after the period-select register is written, where select is bits [SEL_W-1:0] of address 2. The counter then reloads and the flag is set again after each further period.
- R3: Writing 1 to a bit in [2:0] of the flag register clears that flag. Writing 0 to a flag bit leaves the flag unchanged.
- R4: When a set event and a clear write reach the same flag in the same cycle, the flag stays 1.
- R5: `irq_o` is 1 one cycle after any flag is 1 while its enable bit in the control register is 1. The enable bits are bit 0 for the timeout, bit 1 for lock and bit 2 for self-clock. With no enabled flag set, `irq_o` is 0.
- R6: While `pstop_i` is 1 and the pseudo-stop run bit (control bit 6) is 0, the real-time counter is frozen and no timeout occurs. When the run bit is 1, the counter keeps counting in pseudo-stop.
- R7: The lock flag (flag bit 1) is set when the synchronized `lock_i` rises and also when it falls. The synchronized lock level reads back at flag register bit 4.
- R8: The self-clock flag (flag bit 2) is set when the self-clock state, read back at flag register bit 5, is entered and also when it is left.
- R9: The self-clock state changes only while the self-clock enable bit (control bit 4) is 1. While that bit is 0, the state holds.
- R10: A failed clock quality check (`qc_fail_i`) always drives entry into the self-clock state. Loss of the external clock (`clk_lost_i`) drives entry only while the clock-monitor enable bit (control bit 5) is 1.
- R11: Any write to the period-select register restarts the real-time count from zero, so the next timeout comes one full period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference clock of the real-time counter |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 flags, 2 period select) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| lock_i | input | 1 | Lock status from the phase-locked loop (asynchronous) |
| qc_fail_i | input | 1 | Failed clock quality check (asynchronous) |
| clk_lost_i | input | 1 | Loss of the external clock from the clock monitor (asynchronous) |
| pstop_i | input | 1 | Chip is in pseudo-stop mode |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with SEL_W=3 and BASE_SHIFT=2, so the periods run from 4 to 512 cycles instead of starting at 1024. With periods this short, a timeout can be pinned to its exact cycle, a select write can restart the count partway through a period, and the count can be frozen and then resumed in pseudo-stop, all within a short run. The lock path and the self-clock path have fixed synchronizer latencies, so a clear write can be aimed at the exact cycle in which a set event lands.

// File: rtl/cgen_irq_pkg.sv
package cgen_irq_pkg;

    // Interrupt source indices (flag and enable bit positions)
    typedef enum logic [1:0] {
        SRC_RTI  = 2'd0,
        SRC_LOCK = 2'd1,
        SRC_SCM  = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;

    // Register addresses
    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_FLAGS = 2'd1,
        ADDR_SEL   = 2'd2
    } reg_addr_e;

    // Control register layout, MSB first
    typedef struct packed {
        logic       rsv7;
        logic       pstop_run;    // bit 6
        logic       clkmon_en;    // bit 5
        logic       scm_mode_en;  // bit 4
        logic       rsv3;
        logic [2:0] ie;           // bits 2:0, indexed by src_e
    } ctrl_t;

    // Width of the real-time counter for a given select width and base shift
    function automatic int rti_cnt_width(int sel_w, int base_shift);
        return (1 << sel_w) - 1 + base_shift;
    endfunction

    // Read image of the flag register
    function automatic logic [7:0] flags_image(logic [NUM_SRC-1:0] flags,
                                               logic lock_lvl, logic scm_state);
        return {2'b00, scm_state, lock_lvl, 1'b0, flags};
    endfunction

endpackage

// File: rtl/cgen_sync2.sv
module cgen_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/cgen_rti_timer.sv
module cgen_rti_timer
    import cgen_irq_pkg::*;
#(
    parameter int SEL_W      = 4,
    parameter int BASE_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    input  logic             run_i,
    output logic             tick_o
);
    localparam int CNT_W = rti_cnt_width(SEL_W, BASE_SHIFT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   span;

    always_comb begin
        span  = (CNT_W+1)'(1) << (int'(sel_i) + BASE_SHIFT);
        limit = CNT_W'(span - (CNT_W+1)'(1));
    end

    assign tick_o = run_i && !restart_i && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R11: a select write restarts the count from zero
    p_restart_zero_r11: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0));

    // R6: a stopped counter does not move
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !restart_i) |=> $stable(cnt_q));

    // R2: the count never passes the selected limit
    p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && $stable(sel_i)) |=> (cnt_q <= limit));

endmodule

// File: rtl/cgen_flag_bank.sv
module cgen_flag_bank
    import cgen_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] flag_q;
    logic         irq_q;

    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[k] <= 1'b0;
            else     flag_q[k] <= set_i[k] | (flag_q[k] & ~clr_i[k]);
        end

        // R4: a set event always leaves the flag at 1
        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> flag_q[k]);

        // R3: a clear with no set event empties the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !flag_q[k]);

        // R3: without a set event the flag cannot rise
        p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
            (!set_i[k] && !flag_q[k]) |=> !flag_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flag_q & en_i);
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    // R5: no enabled flag means no request in the next cycle
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & en_i) == '0) |=> !irq_o);

endmodule

// File: rtl/cgen_irq_unit.sv
module cgen_irq_unit
    import cgen_irq_pkg::*;
#(
    parameter int SEL_W      = 4,
    parameter int BASE_SHIFT = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       lock_i,
    input  logic       qc_fail_i,
    input  logic       clk_lost_i,
    input  logic       pstop_i,
    output logic       irq_o
);
    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] sel_q;

    logic             wr_ctrl, wr_flags, wr_sel;
    logic [2:0]       async_in, sync_out;
    logic             lock_lvl, qc_fail_s, clk_lost_s;
    logic             lock_prev_q, scm_state_q, scm_prev_q;
    logic             lock_chg, scm_chg, scm_cause;
    logic             rti_tick, rti_run;
    logic [NUM_SRC-1:0] set_vec, clr_vec, flags;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_flags = wr_en && (wr_addr == ADDR_FLAGS);
    assign wr_sel   = wr_en && (wr_addr == ADDR_SEL);

    // Software registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data & 8'h77);
            if (wr_sel)  sel_q  <= wr_data[SEL_W-1:0];
        end
    end

    // Synchronize the asynchronous status inputs
    assign async_in = {clk_lost_i, qc_fail_i, lock_i};

    cgen_sync2 #(.W(3)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (async_in),
        .sync_o  (sync_out)
    );

    assign lock_lvl   = sync_out[0];
    assign qc_fail_s  = sync_out[1];
    assign clk_lost_s = sync_out[2];

    // Self-clock state: follows its causes only while enabled
    assign scm_cause = qc_fail_s | (ctrl_q.clkmon_en & clk_lost_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_prev_q <= 1'b0;
            scm_state_q <= 1'b0;
            scm_prev_q  <= 1'b0;
        end else begin
            lock_prev_q <= lock_lvl;
            if (ctrl_q.scm_mode_en) scm_state_q <= scm_cause;
            scm_prev_q  <= scm_state_q;
        end
    end

    assign lock_chg = lock_lvl ^ lock_prev_q;
    assign scm_chg  = scm_state_q ^ scm_prev_q;

    // Real-time counter
    assign rti_run = !pstop_i || ctrl_q.pstop_run;

    cgen_rti_timer #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) rti_i (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel_q),
        .restart_i (wr_sel),
        .run_i     (rti_run),
        .tick_o    (rti_tick)
    );

    // Flag bank
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_RTI]  = rti_tick;
        set_vec[SRC_LOCK] = lock_chg;
        set_vec[SRC_SCM]  = scm_chg;
        clr_vec           = wr_flags ? wr_data[NUM_SRC-1:0] : '0;
    end

    cgen_flag_bank #(.N(NUM_SRC)) flags_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .en_i   (ctrl_q.ie),
        .flag_o (flags),
        .irq_o  (irq_o)
    );

    // Read mux
    always_comb begin
        case (rd_addr)
            ADDR_CTRL:  rd_data = ctrl_q;
            ADDR_FLAGS: rd_data = flags_image(flags, lock_lvl, scm_state_q);
            ADDR_SEL:   rd_data = 8'(sel_q);
            default:    rd_data = 8'h00;
        endcase
    end

    // R9: the self-clock state holds while the mode enable is clear
    p_scm_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.scm_mode_en |=> $stable(scm_state_q));

    // R10: with no quality failure and the monitor off, the state cannot be entered
    p_loss_gated_r10: assert property (@(posedge clk) disable iff (rst)
        (!qc_fail_s && !ctrl_q.clkmon_en && !scm_state_q) |=> !scm_state_q);

    // R7: a lock change reaches the lock flag
    p_lock_flag_r7: assert property (@(posedge clk) disable iff (rst)
        lock_chg |=> flags[SRC_LOCK]);

    // R8: a self-clock change reaches the self-clock flag
    p_scm_flag_r8: assert property (@(posedge clk) disable iff (rst)
        scm_chg |=> flags[SRC_SCM]);

endmodule

// File: tb/cgen_irq_unit_tb_top.sv
module cgen_irq_unit_tb_top;
    localparam int SEL_W      = 3;
    localparam int BASE_SHIFT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       lock_i = 1'b0, qc_fail_i = 1'b0, clk_lost_i = 1'b0, pstop_i = 1'b0;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] ctrl_sh = '0;

    always #5 clk = ~clk;

    cgen_irq_unit #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lock_i(lock_i), .qc_fail_i(qc_fail_i),
        .clk_lost_i(clk_lost_i), .pstop_i(pstop_i), .irq_o(irq_o)
    );

    function automatic int period(int sel);
        return 1 << (sel + BASE_SHIFT);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_ctrl(logic [7:0] v);
        ctrl_sh = v;
        wr(2'd0, v);
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd1, d); check("R1 flags", d, 0);
        rd(2'd2, d); check("R1 select", d, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic test_rti_period(int sel, string req);
        logic [7:0] d;
        int p = period(sel);
        wr(2'd2, 8'(sel));          // after edge 0
        wr(2'd1, 8'h01);            // after edge 1
        wait_cyc(p - 2);            // after edge p-1
        rd(2'd1, d); check({req, " before timeout"}, d[0], 0);
        wait_cyc(1);
        rd(2'd1, d); check({req, " at timeout"}, d[0], 1);
        wr(2'd1, 8'h01);
        wait_cyc(p - 2);
        rd(2'd1, d); check({req, " reload before"}, d[0], 0);
        wait_cyc(1);
        rd(2'd1, d); check({req, " reload at"}, d[0], 1);
    endtask

    task automatic test_restart();
        logic [7:0] d;
        int p = period(1);
        wr(2'd2, 8'd1);
        wait_cyc(p - 3);
        wr(2'd2, 8'd1);             // restart partway through
        wr(2'd1, 8'h01);
        wait_cyc(p - 2);
        rd(2'd1, d); check("R11 no timeout from old count", d[0], 0);
        wait_cyc(1);
        rd(2'd1, d); check("R11 timeout after restart", d[0], 1);
    endtask

    task automatic test_pstop();
        logic [7:0] d;
        pstop_i = 1'b1;
        set_ctrl(8'h00);
        wr(2'd2, 8'd0);
        wr(2'd1, 8'h01);
        wait_cyc(20);
        rd(2'd1, d); check("R6 frozen in pseudo-stop", d[0], 0);
        set_ctrl(8'h40);            // run bit on, counting starts next edge
        wait_cyc(period(0) - 1);
        rd(2'd1, d); check("R6 running before timeout", d[0], 0);
        wait_cyc(1);
        rd(2'd1, d); check("R6 runs in pseudo-stop with run bit", d[0], 1);
        pstop_i = 1'b0;
        set_ctrl(8'h00);
    endtask

    task automatic test_lock();
        logic [7:0] d;
        wr(2'd1, 8'h02);
        lock_i = 1'b1;
        wait_cyc(4);
        rd(2'd1, d);
        check("R7 flag on lock rise", d[1], 1);
        check("R7 lock level", d[4], 1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R3 write 0 keeps flag", d[1], 1);
        wr(2'd1, 8'h02);
        rd(2'd1, d); check("R3 write 1 clears flag", d[1], 0);
        lock_i = 1'b0;
        wait_cyc(4);
        rd(2'd1, d);
        check("R7 flag on lock fall", d[1], 1);
        check("R7 lock level low", d[4], 0);
        wr(2'd1, 8'h02);
    endtask

    task automatic test_set_wins();
        logic [7:0] d;
        lock_i = 1'b1;              // set lands on the third edge
        wait_cyc(2);
        wr(2'd1, 8'h02);            // clear lands on the same edge
        rd(2'd1, d); check("R4 set beats clear", d[1], 1);
        wr(2'd1, 8'h02);
        rd(2'd1, d); check("R4 later clear works", d[1], 0);
        lock_i = 1'b0;
        wait_cyc(4);
        wr(2'd1, 8'h02);
    endtask

    task automatic test_irq();
        logic [7:0] d;
        set_ctrl(8'h00);
        lock_i = 1'b1;
        wait_cyc(5);
        check("R5 masked flag gives no irq", irq_o, 0);
        set_ctrl(8'h02);
        wait_cyc(1);
        check("R5 enabled flag raises irq", irq_o, 1);
        wr(2'd1, 8'h02);
        wait_cyc(1);
        check("R5 irq drops after clear", irq_o, 0);
        lock_i = 1'b0;
        wait_cyc(4);
        wr(2'd1, 8'h02);
        set_ctrl(8'h00);
        rd(2'd0, d);
    endtask

    task automatic test_scm();
        logic [7:0] d;
        set_ctrl(8'h00);            // mode enable off
        wr(2'd1, 8'h04);
        qc_fail_i = 1'b1;
        wait_cyc(6);
        rd(2'd1, d);
        check("R9 state held with enable off", d[5], 0);
        check("R9 no flag with enable off", d[2], 0);
        set_ctrl(8'h10);            // mode enable on
        wait_cyc(3);
        rd(2'd1, d);
        check("R8 entry sets state", d[5], 1);
        check("R8 entry sets flag", d[2], 1);
        wr(2'd1, 8'h04);
        qc_fail_i = 1'b0;
        wait_cyc(5);
        rd(2'd1, d);
        check("R8 exit clears state", d[5], 0);
        check("R8 exit sets flag", d[2], 1);
        wr(2'd1, 8'h04);
        clk_lost_i = 1'b1;          // monitor off
        wait_cyc(6);
        rd(2'd1, d);
        check("R10 clock loss ignored with monitor off", d[5], 0);
        check("R10 no flag with monitor off", d[2], 0);
        set_ctrl(8'h34);            // monitor on, self-clock ie on
        wait_cyc(3);
        rd(2'd1, d);
        check("R10 clock loss enters with monitor on", d[5], 1);
        check("R10 flag on clock loss", d[2], 1);
        check("R5 self-clock irq", irq_o, 1);
        clk_lost_i = 1'b0;
        wait_cyc(5);
        set_ctrl(8'h00);
        wr(2'd1, 8'h07);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_rti_period(0, "R2 sel0");
        test_rti_period(2, "R2 sel2");
        test_restart();
        test_pstop();
        test_lock();
        test_set_wins();
        test_irq();
        test_scm();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule